// File: doc/BRIEF.md
# Dual-Channel Boost Pulse Timer

This block drives the two boost enables of a unipolar stepper drive that uses a short high-voltage boost after each phase change. It has one channel for winding pair A and one for winding pair B. Each channel watches the state vector that the phase sequencer presents for its pair. When that vector changes, the channel raises its boost enable for a programmed number of clock cycles and then drops it by itself. The idea is to speed up the current rise at every phase shift without ever leaving the boost supply connected.

Both channels take their length from one shared duration input, but each channel counts on its own. A shared hold input can stretch a running pulse: while hold is high, every active channel keeps its count frozen and its enable on. Inhibit clears both channels, and so does reset. The enables are taken straight from flops, so they cannot glitch. Each channel also reports a busy flag.

Top module: `bilevel_boost_timer`

## Requirements
- R1: While reset is asserted, and at the first clock edge after reset is asserted, boost_a, boost_b, busy_a and busy_b are all 0.
- R2: A change of phase_a between two consecutive clock edges makes boost_a go high at the edge where the change is first sampled. With hold low and no further change, boost_a then stays high for exactly dur_cfg clock cycles.
- R3: The channels are independent. A change of phase_b triggers only boost_b, with the same timing as R2. A change of phase_a never alters boost_b.
- R4: A phase change on a channel that is already active reloads the count to the full dur_cfg. The pulse then ends dur_cfg cycles after that retrigger edge.
- R5: When dur_cfg is 0 at the edge where a change is sampled, the change starts no pulse. A pulse that is already running finishes its loaded count and is not affected by dur_cfg later becoming 0.
- R6: While hold is 1, an active channel keeps its remaining count and its enable stays high. When hold returns to 0, the count resumes, so the pulse lasts dur_cfg cycles plus the number of held cycles.
- R7: inhibit high at a clock edge clears both channels at that edge. A phase change that is sampled while inhibit is high never produces a pulse, including after inhibit is released.
- R8: busy_a equals boost_a and busy_b equals boost_b in every cycle.
- R9: dur_cfg is captured only at the edge that starts or restarts a pulse. Changing it while a pulse runs does not alter that pulse's length.
- R10: At the first clock edge after reset is released, the phase inputs are only recorded. A non-zero phase value present at that edge starts no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| inhibit | input | 1 | Clears both channels while high |
| hold | input | 1 | Freezes the count of every active channel while high |
| dur_cfg | input | DUR_W (16) | Pulse length in clock cycles; 0 disables new pulses |
| phase_a | input | PH_W (2) | Current phase state of winding pair A |
| phase_b | input | PH_W (2) | Current phase state of winding pair B |
| boost_a | output | 1 | Registered boost enable, channel A |
| boost_b | output | 1 | Registered boost enable, channel B |
| busy_a | output | 1 | Channel A active |
| busy_b | output | 1 | Channel B active |

## Verification
The properties assume that the phase vectors, hold, inhibit and dur_cfg are synchronous to clk and stable around the rising edge. They also assume that the value dur_cfg holds at a trigger edge is the length intended for that pulse. The stimulus respects this by changing every input only on the falling edge of the clock. Phase changes are one-cycle events on a held vector, and dur_cfg is kept small so that each pulse ends within a few tens of cycles.

// File: rtl/bb_boost_pkg.sv
package bb_boost_pkg;

  localparam int NUM_CH = 2;

  // Per-cycle decision taken by a boost channel
  typedef enum logic [2:0] {
    ACT_IDLE  = 3'd0,
    ACT_CLEAR = 3'd1,
    ACT_LOAD  = 3'd2,
    ACT_HOLD  = 3'd3,
    ACT_COUNT = 3'd4,
    ACT_END   = 3'd5
  } bb_act_e;

endpackage

// File: rtl/bb_change_det.sv
module bb_change_det #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] state_i,
  output logic         chg_o
);

  logic [W-1:0] prev_q;
  logic         armed_q;

  // The first edge after reset only records the input
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= state_i;
      armed_q <= 1'b1;
    end
  end

  assign chg_o = armed_q && (state_i != prev_q);

  // A vector that holds its value across an edge reports no change
  p_no_chg_when_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $stable(state_i)) |-> !chg_o);

endmodule

// File: rtl/bb_oneshot.sv
module bb_oneshot
  import bb_boost_pkg::*;
#(
  parameter int DUR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inhibit,
  input  logic             hold,
  input  logic             fire,
  input  logic [DUR_W-1:0] dur_cfg,
  output logic             on_o
);

  localparam logic [DUR_W-1:0] ONE = DUR_W'(1);

  function automatic logic is_last(input logic [DUR_W-1:0] c);
    return c == ONE;
  endfunction

  logic [DUR_W-1:0] cnt_q;
  logic             on_q;
  logic             cfg_zero;
  bb_act_e          act;

  assign cfg_zero = (dur_cfg == '0);

  always_comb begin
    if (inhibit)                   act = ACT_CLEAR;
    else if (fire && !cfg_zero)    act = ACT_LOAD;
    else if (!on_q)                act = ACT_IDLE;
    else if (hold)                 act = ACT_HOLD;
    else if (is_last(cnt_q))       act = ACT_END;
    else                           act = ACT_COUNT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      on_q  <= 1'b0;
    end else begin
      case (act)
        ACT_CLEAR, ACT_END: begin
          cnt_q <= '0;
          on_q  <= 1'b0;
        end
        ACT_LOAD: begin
          cnt_q <= dur_cfg;
          on_q  <= 1'b1;
        end
        ACT_COUNT: cnt_q <= cnt_q - ONE;
        default: ;
      endcase
    end
  end

  assign on_o = on_q;

  p_inh_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> (!on_q && cnt_q == '0));

  p_load_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !cfg_zero && !inhibit) |=> (on_q && cnt_q == $past(dur_cfg)));

  p_zero_no_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!on_q && !inhibit && cfg_zero) |=> !on_q);

  p_hold_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (on_q && hold && !inhibit && !fire) |=> (on_q && $stable(cnt_q)));

  p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (on_q && !hold && !inhibit && !fire && cnt_q > ONE)
      |=> (on_q && cnt_q == $past(cnt_q) - ONE));

  p_active_has_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    on_q |-> (cnt_q != '0));

endmodule

// File: rtl/bilevel_boost_timer.sv
module bilevel_boost_timer
  import bb_boost_pkg::*;
#(
  parameter int DUR_W = 16,
  parameter int PH_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inhibit,
  input  logic             hold,
  input  logic [DUR_W-1:0] dur_cfg,
  input  logic [PH_W-1:0]  phase_a,
  input  logic [PH_W-1:0]  phase_b,
  output logic             boost_a,
  output logic             boost_b,
  output logic             busy_a,
  output logic             busy_b
);

  logic [PH_W-1:0]   ph   [NUM_CH];
  logic [NUM_CH-1:0] chg;
  logic [NUM_CH-1:0] on;

  assign ph[0] = phase_a;
  assign ph[1] = phase_b;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    bb_change_det #(.W(PH_W)) u_det (
      .clk     (clk),
      .rst_n   (rst_n),
      .state_i (ph[ch]),
      .chg_o   (chg[ch])
    );

    bb_oneshot #(.DUR_W(DUR_W)) u_shot (
      .clk     (clk),
      .rst_n   (rst_n),
      .inhibit (inhibit),
      .hold    (hold),
      .fire    (chg[ch]),
      .dur_cfg (dur_cfg),
      .on_o    (on[ch])
    );
  end

  assign boost_a = on[0];
  assign boost_b = on[1];
  assign busy_a  = on[0];
  assign busy_b  = on[1];

  p_inh_both_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inhibit) |-> (!boost_a && !boost_b));

  p_b_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!boost_b && !chg[1]) |=> !boost_b);

endmodule

// File: tb/bilevel_boost_timer_tb.sv
module bilevel_boost_timer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DUR_W = 16;
  localparam int PH_W  = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             inhibit, hold;
  logic [DUR_W-1:0] dur_cfg;
  logic [PH_W-1:0]  phase_a, phase_b;
  logic             boost_a, boost_b, busy_a, busy_b;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";

  typedef struct {
    logic [3:0] exp;   // {boost_a, boost_b, busy_a, busy_b}
    string      req;
  } item_t;
  item_t sb_q[$];

  // reference state per channel
  bit         m_on  [2];
  int         m_cnt [2];
  logic [1:0] m_prev[2];
  bit         m_armed;

  always #(CLK_PERIOD/2) clk = ~clk;

  bilevel_boost_timer #(.DUR_W(DUR_W), .PH_W(PH_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .inhibit(inhibit), .hold(hold),
    .dur_cfg(dur_cfg), .phase_a(phase_a), .phase_b(phase_b),
    .boost_a(boost_a), .boost_b(boost_b), .busy_a(busy_a), .busy_b(busy_b)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s outputs{ba,bb,ya,yb} actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // one clock of stimulus plus the expected outcome of that edge
  task automatic step(input logic [1:0] pa, input logic [1:0] pb,
                      input bit inh, input bit hd, input int dur);
    logic [1:0] phv[2];
    @(negedge clk);
    rst_n = 1'b1;
    phase_a = pa; phase_b = pb; inhibit = inh; hold = hd; dur_cfg = DUR_W'(dur);
    phv[0] = pa; phv[1] = pb;
    for (int c = 0; c < 2; c++) begin
      bit moved;
      moved = m_armed && (phv[c] != m_prev[c]);
      m_prev[c] = phv[c];
      if (inh) begin
        m_on[c] = 0; m_cnt[c] = 0;
      end else if (moved && dur != 0) begin
        m_on[c] = 1; m_cnt[c] = dur;
      end else if (m_on[c] && !hd) begin
        if (m_cnt[c] == 1) begin m_on[c] = 0; m_cnt[c] = 0; end
        else m_cnt[c]--;
      end
    end
    m_armed = 1;
    sb_q.push_back('{exp: {m_on[0], m_on[1], m_on[0], m_on[1]}, req: cur_req});
  endtask

  task automatic idle(input int n, input logic [1:0] pa, input logic [1:0] pb,
                      input bit hd, input int dur);
    for (int i = 0; i < n; i++) step(pa, pb, 0, hd, dur);
  endtask

  // monitor: compare each edge's result against the queued expectation
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(it.req, {boost_a, boost_b, busy_a, busy_b}, it.exp);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 4000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; inhibit = 0; hold = 0; dur_cfg = '0;
    phase_a = 2'b01; phase_b = 2'b10;
    m_armed = 0;
    for (int c = 0; c < 2; c++) begin m_on[c] = 0; m_cnt[c] = 0; m_prev[c] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", {boost_a, boost_b, busy_a, busy_b}, 4'b0000);

    // R10: non-zero phases at release produce no pulse
    cur_req = "R10";
    step(2'b01, 2'b10, 0, 0, 5);
    idle(3, 2'b01, 2'b10, 0, 5);

    // R2: channel A pulse of exactly 5 cycles
    cur_req = "R2";
    step(2'b11, 2'b10, 0, 0, 5);
    idle(8, 2'b11, 2'b10, 0, 5);

    // R3: channel B alone, then both together
    cur_req = "R3";
    step(2'b11, 2'b00, 0, 0, 4);
    idle(6, 2'b11, 2'b00, 0, 4);
    step(2'b10, 2'b01, 0, 0, 3);
    idle(5, 2'b10, 2'b01, 0, 3);

    // R4: retrigger restarts full count
    cur_req = "R4";
    step(2'b00, 2'b01, 0, 0, 6);
    idle(3, 2'b00, 2'b01, 0, 6);
    step(2'b01, 2'b01, 0, 0, 6);
    idle(9, 2'b01, 2'b01, 0, 6);

    // R5: zero duration blocks start, running pulse finishes
    cur_req = "R5";
    step(2'b11, 2'b01, 0, 0, 0);
    idle(3, 2'b11, 2'b01, 0, 0);
    step(2'b10, 2'b01, 0, 0, 4);
    step(2'b10, 2'b01, 0, 0, 0);
    idle(6, 2'b10, 2'b01, 0, 0);

    // R6: hold stretches the pulse
    cur_req = "R6";
    step(2'b00, 2'b11, 0, 0, 4);
    idle(1, 2'b00, 2'b11, 0, 4);
    idle(7, 2'b00, 2'b11, 1, 4);
    idle(6, 2'b00, 2'b11, 0, 4);

    // R7: inhibit clears; change during inhibit never fires
    cur_req = "R7";
    step(2'b01, 2'b10, 0, 0, 8);
    idle(2, 2'b01, 2'b10, 0, 8);
    step(2'b01, 2'b10, 1, 0, 8);
    step(2'b11, 2'b00, 1, 0, 8);
    idle(6, 2'b11, 2'b00, 0, 8);

    // R9: duration change mid-pulse is ignored
    cur_req = "R9";
    step(2'b01, 2'b00, 0, 0, 3);
    idle(1, 2'b01, 2'b00, 0, 9);
    idle(9, 2'b01, 2'b00, 0, 9);

    // R8: busy mirrors boost, checked with every scoreboard entry
    cur_req = "R8";
    step(2'b11, 2'b01, 0, 0, 2);
    idle(4, 2'b11, 2'b01, 0, 2);

    @(posedge clk); #2;
    @(posedge clk); #2;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule